// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block commits accepted receive frames into a circular region of packet memory. The region consists of 256-byte pages from a start page up to, but not including, a stop page. A current-page pointer marks where the next frame goes. A host-owned boundary page marks how far the host has consumed. From these two pointers the block decides whether a maximum-size frame still fits. If it does not fit, or if the controller is stopped, any frame offered at that moment is discarded.

For each accepted frame, the block first works out where the following frame will begin. It then writes a 4-byte descriptor at the start of the current page and streams the payload into memory right after it. The write address folds back to the start page whenever it reaches the stop page. Frames under the minimum length are extended with zero bytes. Once the last byte is stored, the current page moves to the precomputed next page, a one-cycle done pulse is raised and the status byte reports a good reception.

Top module: `rxring_writer`

## Requirements
- R1: `frm_ready_o` is high only when the block is idle, `stop_cmd_i` is low and free space is at least 1518 bytes. Free space in bytes is (boundary − current)·256 when current < boundary, and otherwise ((stop − start) − (current − boundary))·256.
- R2: A `frm_start_i` pulse seen while `frm_ready_o` is low is dropped. No memory write follows, the current page is unchanged and `byte_rdy_o` stays low.
- R3: For an accepted frame, the block writes 4 descriptor bytes to byte offsets 0, 1, 2 and 3 of the current page, in the cycles right after the start pulse. The bytes are: offset 0 status 0x01, offset 1 next-frame page, offset 2 length bits 7:0, offset 3 length bits 15:8. The length is the padded frame size plus 4.
- R4: The next-frame page is the current page plus ceil((length + 4) / 256). The span (stop − start) is subtracted when the result is equal to or beyond the stop page.
- R5: Payload bytes go to consecutive addresses starting at offset 4 of the current page. An address that reaches stop·256 folds to start·256. Every write lands inside [start·256, stop·256).
- R6: A frame shorter than 60 bytes is followed by zero bytes up to a size of 60. Its length field then reads 64.
- R7: When the last byte is stored, `cur_pg_o` takes the next-frame page and `rx_done_o` is high for exactly one cycle. `status_o` reads 0x01 from then on (0x00 after reset).
- R8: `byte_vld_i` has no effect while `byte_rdy_o` is low. No memory write results.
- R9: `cur_wr_i` loads `cur_wdata_i` into the current page while the block is idle. Otherwise the current page changes only on a frame commit. Reset value is 0.
- R10: A frame offered while `stop_cmd_i` is high is dropped, even when space is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_pg_i | input | 8 | First page of the ring |
| stop_pg_i | input | 8 | Page one past the end of the ring |
| bnd_pg_i | input | 8 | Host boundary page |
| cur_wr_i | input | 1 | Load the current page |
| cur_wdata_i | input | 8 | Value for the current page |
| stop_cmd_i | input | 1 | Controller stopped; frames are refused |
| frm_start_i | input | 1 | Frame offer strobe |
| frm_len_i | input | 11 | Frame size in bytes, valid with the strobe |
| byte_vld_i | input | 1 | Payload byte valid |
| byte_data_i | input | 8 | Payload byte |
| byte_last_i | input | 1 | Marks the final payload byte |
| byte_rdy_o | output | 1 | Payload byte is taken this cycle if valid |
| frm_ready_o | output | 1 | A frame offered now is accepted |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 16 | Memory byte address |
| mem_data_o | output | 8 | Memory write data |
| cur_pg_o | output | 8 | Current page pointer |
| rx_done_o | output | 1 | One-cycle frame-committed pulse |
| status_o | output | 8 | Receive status byte |

## Verification
The hardest corners to reach are the pointer arithmetic at the end of the ring. One case is a payload that crosses the stop page mid-frame. Another is a next-frame page that lands exactly on the stop page and must fold to the start page. A third is free space sitting just one page either side of the 1518-byte limit. The stimulus loads the current page directly and places the boundary page so that free space is exactly five or six pages. It then sends frames whose lengths put the fold in the payload or exactly on the next-page computation. Memory captured from the write port is compared against a software ring model.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  typedef enum logic [1:0] {S_IDLE, S_HDR, S_DATA, S_PAD} rx_state_e;
  localparam int MIN_FRAME = 60;
  localparam int MAX_FRAME = 1514;
  localparam int HDR_BYTES = 4;
  localparam logic [7:0] RX_OK = 8'h01;
endpackage

// File: rtl/rxring_space.sv
module rxring_space #(
  parameter int PG_W = 8,
  parameter int NEED = 1518
) (
  input  logic [PG_W-1:0] cur_i,
  input  logic [PG_W-1:0] bnd_i,
  input  logic [PG_W-1:0] start_i,
  input  logic [PG_W-1:0] stop_i,
  output logic            full_o
);
  localparam int BW = PG_W + 10;
  localparam logic signed [BW-1:0] NEED_B = BW'(NEED);

  logic signed [PG_W+1:0] cur_s, bnd_s, start_s, stop_s, avail_pg;
  logic signed [BW-1:0]   avail_b;

  always_comb begin
    cur_s   = $signed({2'b00, cur_i});
    bnd_s   = $signed({2'b00, bnd_i});
    start_s = $signed({2'b00, start_i});
    stop_s  = $signed({2'b00, stop_i});
    if (cur_i < bnd_i) avail_pg = bnd_s - cur_s;
    else               avail_pg = (stop_s - start_s) - (cur_s - bnd_s);
    avail_b = $signed({avail_pg, 8'h00});
    full_o  = avail_b < NEED_B;
  end
endmodule

// File: rtl/rxring_nextpg.sv
module rxring_nextpg #(
  parameter int PG_W  = 8,
  parameter int TOT_W = 12
) (
  input  logic [PG_W-1:0]  cur_i,
  input  logic [PG_W-1:0]  start_i,
  input  logic [PG_W-1:0]  stop_i,
  input  logic [TOT_W-1:0] tot_i,
  output logic [PG_W-1:0]  next_o
);
  localparam int SUM_W = TOT_W + 2;
  localparam int RW    = PG_W + 2;

  logic [SUM_W-1:0] sum;
  logic [RW-1:0]    raw;

  always_comb begin
    // 4 trailing bytes then round up to whole pages
    sum = SUM_W'(tot_i) + SUM_W'(4 + 255);
    raw = RW'(cur_i) + RW'(sum >> 8);
    if (raw >= RW'(stop_i)) raw = raw - (RW'(stop_i) - RW'(start_i));
    next_o = raw[PG_W-1:0];
  end
endmodule

// File: rtl/rxring_writer.sv
module rxring_writer
  import rxring_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-9:0] start_pg_i,
  input  logic [ADDR_W-9:0] stop_pg_i,
  input  logic [ADDR_W-9:0] bnd_pg_i,
  input  logic              cur_wr_i,
  input  logic [ADDR_W-9:0] cur_wdata_i,
  input  logic              stop_cmd_i,
  input  logic              frm_start_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_data_i,
  input  logic              byte_last_i,
  output logic              byte_rdy_o,
  output logic              frm_ready_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_data_o,
  output logic [ADDR_W-9:0] cur_pg_o,
  output logic              rx_done_o,
  output logic [7:0]        status_o
);
  localparam int PG_W  = ADDR_W - 8;
  localparam int TOT_W = LEN_W + 1;

  rx_state_e         state_q;
  logic [1:0]        hdr_q;
  logic [ADDR_W-1:0] wa_q, wa_nx;
  logic [LEN_W-1:0]  cnt_q;
  logic [PG_W-1:0]   cur_q, next_q, next_c;
  logic [TOT_W-1:0]  tot_q, tot_c;
  logic              done_q, full;
  logic [7:0]        stat_q;

  rxring_space #(.PG_W(PG_W), .NEED(MAX_FRAME + HDR_BYTES)) u_space (
    .cur_i(cur_q), .bnd_i(bnd_pg_i), .start_i(start_pg_i), .stop_i(stop_pg_i),
    .full_o(full)
  );

  always_comb begin
    if (frm_len_i < LEN_W'(MIN_FRAME)) tot_c = TOT_W'(MIN_FRAME + HDR_BYTES);
    else                               tot_c = TOT_W'(frm_len_i) + TOT_W'(HDR_BYTES);
  end

  rxring_nextpg #(.PG_W(PG_W), .TOT_W(TOT_W)) u_next (
    .cur_i(cur_q), .start_i(start_pg_i), .stop_i(stop_pg_i), .tot_i(tot_c),
    .next_o(next_c)
  );

  assign frm_ready_o = (state_q == S_IDLE) && !stop_cmd_i && !full;
  assign byte_rdy_o  = (state_q == S_DATA);
  assign cur_pg_o    = cur_q;
  assign rx_done_o   = done_q;
  assign status_o    = stat_q;

  always_comb begin
    wa_nx = wa_q + ADDR_W'(1);
    if (wa_nx == {stop_pg_i, 8'h00}) wa_nx = {start_pg_i, 8'h00};
  end

  always_comb begin
    mem_we_o   = 1'b0;
    mem_addr_o = wa_q;
    mem_data_o = 8'h00;
    unique case (state_q)
      S_HDR: begin
        mem_we_o   = 1'b1;
        mem_addr_o = {cur_q, 6'h00, hdr_q};
        unique case (hdr_q)
          2'd0: mem_data_o = RX_OK;
          2'd1: mem_data_o = 8'(next_q);
          2'd2: mem_data_o = tot_q[7:0];
          default: mem_data_o = 8'(tot_q >> 8);
        endcase
      end
      S_DATA: begin
        mem_we_o   = byte_vld_i;
        mem_data_o = byte_data_i;
      end
      S_PAD: mem_we_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      hdr_q   <= '0;
      wa_q    <= '0;
      cnt_q   <= '0;
      cur_q   <= '0;
      next_q  <= '0;
      tot_q   <= '0;
      done_q  <= 1'b0;
      stat_q  <= 8'h00;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (cur_wr_i) cur_q <= cur_wdata_i;
          if (frm_start_i && frm_ready_o) begin
            next_q  <= next_c;
            tot_q   <= tot_c;
            hdr_q   <= '0;
            cnt_q   <= '0;
            wa_q    <= {cur_q, 8'(HDR_BYTES)};
            state_q <= S_HDR;
          end
        end
        S_HDR: begin
          hdr_q <= hdr_q + 2'd1;
          if (hdr_q == 2'd3) state_q <= S_DATA;
        end
        S_DATA: if (byte_vld_i) begin
          wa_q  <= wa_nx;
          cnt_q <= cnt_q + LEN_W'(1);
          if (byte_last_i) begin
            if (cnt_q + LEN_W'(1) < LEN_W'(MIN_FRAME)) state_q <= S_PAD;
            else begin
              cur_q   <= next_q;
              done_q  <= 1'b1;
              stat_q  <= RX_OK;
              state_q <= S_IDLE;
            end
          end
        end
        S_PAD: begin
          wa_q  <= wa_nx;
          cnt_q <= cnt_q + LEN_W'(1);
          if (cnt_q + LEN_W'(1) >= LEN_W'(MIN_FRAME)) begin
            cur_q   <= next_q;
            done_q  <= 1'b1;
            stat_q  <= RX_OK;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_drop_no_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && !frm_ready_o) |=> !mem_we_o);
  assert_hdr_at_cur_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frm_start_i && frm_ready_o) |=> (mem_we_o && mem_addr_o == {$past(cur_pg_o), 8'h00}));
  assert_wr_in_ring_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (mem_addr_o >= {start_pg_i, 8'h00} && mem_addr_o < {stop_pg_i, 8'h00}));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_done_o |=> !rx_done_o);
  assert_cur_moves_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_pg_o != $past(cur_pg_o)) |-> (rx_done_o || $past(cur_wr_i)));
  assert_no_wr_unready_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !mem_we_o);
endmodule

// File: tb/tb_rxring_writer.sv
`timescale 1ns/1ps
module tb_rxring_writer;
  localparam int START = 8'h40;
  localparam int STOP  = 8'h4C;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] start_pg = 8'(START), stop_pg = 8'(STOP), bnd_pg = 8'h40;
  logic cur_wr = 0; logic [7:0] cur_wdata = 0;
  logic stop_cmd = 0, frm_start = 0; logic [10:0] frm_len = 0;
  logic byte_vld = 0, byte_last = 0; logic [7:0] byte_data = 0;
  logic byte_rdy, frm_ready, mem_we, rx_done;
  logic [15:0] mem_addr; logic [7:0] mem_data, cur_pg, status;

  int checks = 0, fails = 0, wr_count = 0;
  logic [7:0] tmem [0:65535];

  always #5 clk = ~clk;

  rxring_writer dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_pg_i(start_pg), .stop_pg_i(stop_pg),
    .bnd_pg_i(bnd_pg), .cur_wr_i(cur_wr), .cur_wdata_i(cur_wdata),
    .stop_cmd_i(stop_cmd), .frm_start_i(frm_start), .frm_len_i(frm_len),
    .byte_vld_i(byte_vld), .byte_data_i(byte_data), .byte_last_i(byte_last),
    .byte_rdy_o(byte_rdy), .frm_ready_o(frm_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_data_o(mem_data), .cur_pg_o(cur_pg),
    .rx_done_o(rx_done), .status_o(status)
  );

  always @(negedge clk) if (rst_ni && mem_we) begin
    tmem[mem_addr] = mem_data;
    wr_count = wr_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'(seed * 3 + i * 5 + (i >> 8));
  endfunction

  function automatic int exp_next(input int cur, input int len);
    int sz = (len < 60) ? 60 : len;
    int nxt = cur * 256 + ((sz + 4 + 4 + 255) & ~255);
    if (nxt >= STOP * 256) nxt -= (STOP - START) * 256;
    return nxt >> 8;
  endfunction

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic fill();
    for (int a = START * 256; a < STOP * 256; a++) tmem[a] = 8'hEE;
  endtask

  task automatic set_cur(input int pg);
    cur_wr = 1; cur_wdata = 8'(pg); tick(); cur_wr = 0;
  endtask

  // offer a frame, stream it, verify memory and pointers
  task automatic frame(input int len, input int seed, input string req);
    int cur0 = cur_pg, nx = exp_next(cur_pg, len), sz, tot, a, bad_i, k;
    logic [7:0] e;
    bit seen;
    sz = (len < 60) ? 60 : len; tot = sz + 4; bad_i = -1;
    fill();
    chk(frm_ready == 1'b1, {req, " R1 ready"}, frm_ready, 1);
    frm_start = 1; frm_len = 11'(len); tick(); frm_start = 0;
    for (int i = 0; i < len; i++) begin
      k = 0;
      while (!byte_rdy && k < 20) begin tick(); k++; end
      byte_vld = 1; byte_data = pat(seed, i); byte_last = (i == len - 1);
      tick();
    end
    byte_vld = 0; byte_last = 0;
    seen = 0;
    for (int c = 0; c < 100; c++) begin
      if (rx_done) begin seen = 1; break; end
      tick();
    end
    chk(seen, {req, " R7 done pulse"}, seen, 1);
    tick();
    chk(!rx_done, {req, " R7 single pulse"}, rx_done, 0);
    chk(tmem[cur0*256] == 8'h01, {req, " R3 status byte"}, tmem[cur0*256], 1);
    chk(tmem[cur0*256+1] == 8'(nx), {req, " R4 next page in header"}, tmem[cur0*256+1], nx);
    chk({tmem[cur0*256+3], tmem[cur0*256+2]} == 16'(tot), {req, " R3 length"},
        {tmem[cur0*256+3], tmem[cur0*256+2]}, tot);
    a = cur0 * 256 + 4;
    for (int i = 0; i < sz; i++) begin
      e = (i < len) ? pat(seed, i) : 8'h00;
      if (tmem[a] !== e && bad_i < 0) bad_i = i;
      a++; if (a == STOP * 256) a = START * 256;
    end
    chk(bad_i < 0, {req, (len < 60) ? " R6 payload+pad" : " R5 payload"}, bad_i, -1);
    chk(cur_pg == 8'(nx), {req, " R7 cur page"}, cur_pg, nx);
    chk(status == 8'h01, {req, " R7 status"}, status, 1);
  endtask

  task automatic dropped(input string req);
    int w0 = wr_count, c0 = cur_pg;
    frm_start = 1; frm_len = 11'd100; tick(); frm_start = 0;
    for (int i = 0; i < 6; i++) begin
      chk(!byte_rdy, {req, " R2 no byte_rdy"}, byte_rdy, 0);
      byte_vld = 1; byte_data = 8'h5A; tick();
    end
    byte_vld = 0; tick();
    chk(wr_count == w0, {req, " R2 no write"}, wr_count - w0, 0);
    chk(cur_pg == 8'(c0), {req, " R2 cur kept"}, cur_pg, c0);
  endtask

  task automatic t_reset();
    chk(cur_pg == 0, "R9 reset cur", cur_pg, 0);
    chk(status == 0, "R7 reset status", status, 0);
    chk(!rx_done && !mem_we && !byte_rdy, "R7 reset outputs", {rx_done, mem_we, byte_rdy}, 0);
  endtask

  task automatic t_idle_bytes();
    int w0 = wr_count;
    set_cur(START);
    chk(cur_pg == 8'(START), "R9 cur load", cur_pg, START);
    byte_vld = 1; byte_data = 8'h33; byte_last = 1;
    repeat (3) tick();
    byte_vld = 0; byte_last = 0; tick();
    chk(wr_count == w0, "R8 idle bytes ignored", wr_count - w0, 0);
  endtask

  task automatic t_full();
    set_cur(8'h42); bnd_pg = 8'h47; tick();
    chk(!frm_ready, "R1 five pages free is full", frm_ready, 0);
    dropped("full");
    bnd_pg = 8'h48; tick();
    chk(frm_ready, "R1 six pages free accepts", frm_ready, 1);
  endtask

  task automatic t_stop();
    stop_cmd = 1; tick();
    chk(!frm_ready, "R10 stopped not ready", frm_ready, 0);
    dropped("R10 stopped");
    stop_cmd = 0; tick();
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_ni = 1; tick();
        t_reset();
        t_idle_bytes();
        bnd_pg = 8'h40;
        frame(100, 1, "basic");
        frame(20, 2, "short");
        frame(60, 3, "exact min");
        t_full();
        t_stop();
        set_cur(8'h4A); bnd_pg = 8'h44; tick();
        frame(600, 4, "R5 wrap in payload");
        set_cur(8'h4B); bnd_pg = 8'h45; tick();
        frame(248, 5, "R4 next on stop");
        set_cur(8'h40); bnd_pg = 8'h40; tick();
        frame(60, 6, "b2b a");
        frame(1514, 7, "b2b max");
        bnd_pg = 8'h46; tick();
        frame(300, 8, "b2b c");
      end
      begin
        #1ms;
        fails++; checks++;
        $display("FAIL watchdog R1 actual=0x0 expected=0x1");
      end
    join_any
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule